// File: doc/BRIEF.md
# Serial Configuration Frame Checker

This block watches a serial configuration stream, one bit per clock in which `bit_vld` is high, and checks each frame as it arrives. A frame opens with a 0-then-1 start pair. A fixed number of payload bits follows, then zero or more alignment pad bits, an 8-bit checksum and eight stop bits. The header is the start pair, the payload and the pad. Its length is always a whole number of bytes, so the checksum byte is the XOR of the header bytes. The first frame after reset or after a program request is the identifier frame. Its leading `ID_BITS` payload bits must match a fixed device code.

The block detects three kinds of fault: a wrong device code, a zero among the stop bits, and a checksum that does not match. On the first fault it stores a two-bit code in the status register (`stat_code`), pulls `init_n` low and ignores all further stream bits. It stays in that state until one of three things happens: `rst`, a pulse on `prog_req`, or a control-register write whose program bit is set. Any of these clears the error and restarts the check at a fresh identifier frame.

Top module: `cfg_frame_checker`

## Requirements
- R1: While `rst` is high, the next clock edge sets `stat_code` to 2'b00 and `init_n` to 1.
- R2: A stream of well-formed frames leaves `stat_code` at 2'b00 and `init_n` high. The stream is an identifier frame whose payload bits 0..ID_BITS-1 equal `DEV_CODE`, most significant bit first, followed by any number of data frames. Any number of valid 1 bits may come before or between frames.
- R3: If the identifier frame's code differs from `DEV_CODE`, `stat_code` becomes 2'b01 on the edge that samples frame bit 1+ID_BITS. Frame bits are numbered from 0 at the first start bit.
- R4: If any of a frame's eight stop bits is 0, `stat_code` becomes 2'b10 on the edge that samples the 1 of the next start pair. The first frame after reset or a program request has no stop field before it, so this check does not apply to it.
- R5: The 8 bits after the header (MSB first) must equal the XOR of the header bytes. On a mismatch, `stat_code` becomes 2'b11 on the edge that samples the last checksum bit. This applies to identifier and data frames alike.
- R6: The checksum covers the start pair and the pad bits as well as the payload. Bytes are taken from frame bit 0 onward, with the earliest bit as MSB. A flipped pad bit is therefore reported as a checksum error.
- R7: The frame length is the smallest multiple of 8 that is at least payload+18 (224 bits for 202 payload bits). The checksum ends at frame bit length-9.
- R8: `init_n` goes low on the same edge that records an error. The first code recorded stays in place: later faults and all further stream bits leave `stat_code` unchanged.
- R9: A `prog_req` pulse returns `stat_code` to 2'b00 and `init_n` to 1 on the next edge. The next frame is then checked as an identifier frame.
- R10: A control write (`ctl_we` high) with `ctl_prog`=1 acts like `prog_req`. A control write with `ctl_prog`=0 has no effect.
- R11: Bits presented while `bit_vld` is low have no effect on frame parsing or on error detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Stream bit strobe |
| bit_in | input | 1 | Stream bit value |
| prog_req | input | 1 | Program request: clear the error and restart |
| ctl_we | input | 1 | Control register write strobe |
| ctl_prog | input | 1 | Program bit of the control word being written |
| init_n | output | 1 | Active-low status: low while an error is held |
| stat_code | output | 2 | Status register: 00 none, 01 identifier, 10 alignment, 11 checksum |

## Verification
Every error is recorded on the clock edge that samples its deciding bit. The bench applies each bit at a falling edge and, for a chosen bit index, compares the outputs at the falling edge just before that bit and again at the falling edge just after it. This pins the identifier error to bit 33, the checksum error to bit 215, and the alignment error to bit 1 of the frame that follows the bad stop field. Clearing by program request or by control write takes one edge, so the bench reads the outputs at the next falling edge. Random idle gaps, with random values on `bit_in`, separate the valid bits throughout the run.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  localparam int START_BITS = 2;
  localparam int CK_BITS    = 8;
  localparam int STOP_BITS  = 8;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_IDENT = 2'b01,
    ERR_ALIGN = 2'b10,
    ERR_CKSUM = 2'b11
  } err_code_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_GOT0 = 2'd1,
    ST_BODY = 2'd2,
    ST_STOP = 2'd3
  } seq_state_e;

  // pad so that start + payload + pad + checksum + stop is a byte multiple
  function automatic int pad_bits(input int payload);
    return (8 - ((payload + START_BITS + CK_BITS + STOP_BITS) % 8)) % 8;
  endfunction

endpackage

// File: rtl/cfc_sequencer.sv
module cfc_sequencer
  import cfc_pkg::*;
#(
  parameter int PAYLOAD_BITS = 202,
  parameter int ID_BITS      = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic lock,
  input  logic bit_vld,
  input  logic bit_in,
  output logic ev_start,
  output logic ev_hdr,
  output logic ev_byte_end,
  output logic ev_ck,
  output logic ev_ck_last,
  output logic ev_id_bit,
  output logic ev_id_last,
  output logic ev_align_bad
);

  localparam int HDR_BITS  = START_BITS + PAYLOAD_BITS + pad_bits(PAYLOAD_BITS);
  localparam int LAST_CK   = HDR_BITS + CK_BITS - 1;
  localparam int LAST_STOP = LAST_CK + STOP_BITS;
  localparam int POS_W     = $clog2(LAST_STOP + 1);

  localparam logic [POS_W-1:0] HDR_P     = POS_W'(HDR_BITS);
  localparam logic [POS_W-1:0] CK_END_P  = POS_W'(LAST_CK);
  localparam logic [POS_W-1:0] STOP_END_P = POS_W'(LAST_STOP);
  localparam logic [POS_W-1:0] BODY_P0   = POS_W'(START_BITS);
  localparam logic [POS_W-1:0] ID_END_P  = POS_W'(START_BITS + ID_BITS);
  localparam logic [POS_W-1:0] ID_LAST_P = POS_W'(START_BITS + ID_BITS - 1);

  seq_state_e       state_q;
  logic [POS_W-1:0] pos_q;
  logic             first_q;
  logic [7:0]       stop_hist_q;
  logic             take;

  always_comb begin
    take         = bit_vld && !lock;
    ev_start     = 1'b0;
    ev_hdr       = 1'b0;
    ev_byte_end  = 1'b0;
    ev_ck        = 1'b0;
    ev_ck_last   = 1'b0;
    ev_id_bit    = 1'b0;
    ev_id_last   = 1'b0;
    ev_align_bad = 1'b0;
    if (take) begin
      case (state_q)
        ST_GOT0: begin
          if (bit_in) begin
            ev_start     = 1'b1;
            ev_align_bad = !first_q && (stop_hist_q != 8'hFF);
          end
        end
        ST_BODY: begin
          if (pos_q < HDR_P) begin
            ev_hdr      = 1'b1;
            ev_byte_end = (pos_q[2:0] == 3'd7);
            ev_id_bit   = first_q && (pos_q < ID_END_P);
            ev_id_last  = first_q && (pos_q == ID_LAST_P);
          end else begin
            ev_ck      = 1'b1;
            ev_ck_last = (pos_q == CK_END_P);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state_q     <= ST_HUNT;
      pos_q       <= '0;
      first_q     <= 1'b1;
      stop_hist_q <= 8'hFF;
    end else if (take) begin
      case (state_q)
        ST_HUNT: begin
          if (!bit_in) state_q <= ST_GOT0;
        end
        ST_GOT0: begin
          if (bit_in) begin
            state_q <= ST_BODY;
            pos_q   <= BODY_P0;
          end
        end
        ST_BODY: begin
          pos_q <= pos_q + 1'b1;
          if (pos_q == CK_END_P) begin
            state_q <= ST_STOP;
            first_q <= 1'b0;
          end
        end
        ST_STOP: begin
          stop_hist_q <= {stop_hist_q[6:0], bit_in};
          pos_q       <= pos_q + 1'b1;
          if (pos_q == STOP_END_P) state_q <= ST_HUNT;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/cfc_xor_accum.sv
module cfc_xor_accum (
  input  logic clk,
  input  logic rst,
  input  logic ev_start,
  input  logic ev_hdr,
  input  logic ev_byte_end,
  input  logic ev_ck,
  input  logic ev_ck_last,
  input  logic bit_in,
  output logic ck_bad
);

  logic [6:0] sh_q;
  logic [7:0] acc_q;
  logic [7:0] nxt;

  assign nxt    = {sh_q, bit_in};
  assign ck_bad = ev_ck_last && (nxt != acc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      acc_q <= '0;
    end else if (ev_start) begin
      sh_q  <= 7'b000_0001;   // start pair 0,1 already shifted in
      acc_q <= '0;
    end else if (ev_hdr || ev_ck) begin
      sh_q <= nxt[6:0];
      if (ev_hdr && ev_byte_end) acc_q <= acc_q ^ nxt;
    end
  end

endmodule

// File: rtl/cfc_ident_cmp.sv
module cfc_ident_cmp #(
  parameter int              ID_BITS  = 32,
  parameter logic [ID_BITS-1:0] DEV_CODE = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_id_bit,
  input  logic ev_id_last,
  input  logic bit_in,
  output logic id_bad
);

  logic [ID_BITS-2:0] sh_q;
  logic [ID_BITS-1:0] nxt;

  assign nxt    = {sh_q, bit_in};
  assign id_bad = ev_id_last && (nxt != DEV_CODE);

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else if (ev_id_bit) sh_q <= nxt[ID_BITS-2:0];
  end

endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
  import cfc_pkg::*;
#(
  parameter int                 PAYLOAD_BITS = 202,
  parameter int                 ID_BITS      = 32,
  parameter logic [ID_BITS-1:0] DEV_CODE     = 32'h3A5C_0F17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       prog_req,
  input  logic       ctl_we,
  input  logic       ctl_prog,
  output logic       init_n,
  output logic [1:0] stat_code
);

  err_code_e code_q;
  err_code_e new_code;
  logic      clear;
  logic      lock;

  logic ev_start, ev_hdr, ev_byte_end, ev_ck, ev_ck_last;
  logic ev_id_bit, ev_id_last, ev_align_bad;
  logic ck_bad, id_bad;

  assign clear = prog_req || (ctl_we && ctl_prog);
  assign lock  = (code_q != ERR_NONE);

  cfc_sequencer #(
    .PAYLOAD_BITS(PAYLOAD_BITS),
    .ID_BITS     (ID_BITS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .restart     (clear),
    .lock        (lock),
    .bit_vld     (bit_vld),
    .bit_in      (bit_in),
    .ev_start    (ev_start),
    .ev_hdr      (ev_hdr),
    .ev_byte_end (ev_byte_end),
    .ev_ck       (ev_ck),
    .ev_ck_last  (ev_ck_last),
    .ev_id_bit   (ev_id_bit),
    .ev_id_last  (ev_id_last),
    .ev_align_bad(ev_align_bad)
  );

  cfc_xor_accum u_xor (
    .clk        (clk),
    .rst        (rst),
    .ev_start   (ev_start),
    .ev_hdr     (ev_hdr),
    .ev_byte_end(ev_byte_end),
    .ev_ck      (ev_ck),
    .ev_ck_last (ev_ck_last),
    .bit_in     (bit_in),
    .ck_bad     (ck_bad)
  );

  cfc_ident_cmp #(
    .ID_BITS (ID_BITS),
    .DEV_CODE(DEV_CODE)
  ) u_id (
    .clk       (clk),
    .rst       (rst),
    .ev_id_bit (ev_id_bit),
    .ev_id_last(ev_id_last),
    .bit_in    (bit_in),
    .id_bad    (id_bad)
  );

  // the three events fall on distinct frame bits; order only fixes the encoding
  always_comb begin
    if (id_bad)            new_code = ERR_IDENT;
    else if (ev_align_bad) new_code = ERR_ALIGN;
    else if (ck_bad)       new_code = ERR_CKSUM;
    else                   new_code = ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code_q <= ERR_NONE;
      init_n <= 1'b1;
    end else if (code_q == ERR_NONE && new_code != ERR_NONE) begin
      code_q <= new_code;
      init_n <= 1'b0;
    end
  end

  assign stat_code = code_q;

endmodule

// File: rtl/cfg_frame_checker_chk.sv
module cfg_frame_checker_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_vld,
  input logic       prog_req,
  input logic       ctl_we,
  input logic       ctl_prog,
  input logic       init_n,
  input logic [1:0] stat_code
);

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (stat_code == 2'b00 && init_n));

  // R8
  init_tracks_code_chk: assert property (@(posedge clk) disable iff (rst)
    init_n == (stat_code == 2'b00));

  // R8
  sticky_code_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_code != 2'b00 && !prog_req && !(ctl_we && ctl_prog)) |=> $stable(stat_code));

  // R9
  prog_clears_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> (stat_code == 2'b00 && init_n));

  // R10
  ctl_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_prog) |=> (stat_code == 2'b00 && init_n));

  // R11
  gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_code == 2'b00 && !bit_vld) |=> stat_code == 2'b00);

endmodule

bind cfg_frame_checker cfg_frame_checker_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_vld  (bit_vld),
  .prog_req (prog_req),
  .ctl_we   (ctl_we),
  .ctl_prog (ctl_prog),
  .init_n   (init_n),
  .stat_code(stat_code)
);

// File: tb/cfg_frame_checker_tb.sv
module cfg_frame_checker_tb;

  localparam int          P    = 202;
  localparam int          IDB  = 32;
  localparam logic [31:0] CODE = 32'h3A5C_0F17;
  localparam int          FL   = ((P + 18 + 7) / 8) * 8;
  localparam int          HB   = FL - 16;
  localparam int          CKL  = FL - 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b1;
  logic       prog_req = 1'b0;
  logic       ctl_we = 1'b0;
  logic       ctl_prog = 1'b0;
  logic       init_n;
  logic [1:0] stat_code;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cfg_frame_checker #(
    .PAYLOAD_BITS(P),
    .ID_BITS     (IDB),
    .DEV_CODE    (CODE)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .prog_req (prog_req),
    .ctl_we   (ctl_we),
    .ctl_prog (ctl_prog),
    .init_n   (init_n),
    .stat_code(stat_code)
  );

  function automatic logic [0:FL-1] build(input bit is_id);
    logic [0:FL-1] f;
    logic [7:0]    ck;
    f    = '1;
    f[0] = 1'b0;
    f[1] = 1'b1;
    for (int i = 0; i < P; i++)
      f[2+i] = (is_id && i < IDB) ? CODE[IDB-1-i] : 1'($urandom_range(0, 1));
    for (int i = 2 + P; i < HB; i++) f[i] = 1'b0;
    ck = '0;
    for (int i = 0; i < HB; i++) ck[7-(i%8)] = ck[7-(i%8)] ^ f[i];
    for (int j = 0; j < 8; j++) f[HB+j] = ck[7-j];
    return f;
  endfunction

  task automatic chk(input string req, input logic [1:0] exp);
    vectors++;
    if (stat_code !== exp || init_n !== (exp == 2'b00)) begin
      miscompares++;
      $display("FAIL %s: stat_code=%0d init_n=%0b, expected stat_code=%0d init_n=%0b",
               req, stat_code, init_n, exp, (exp == 2'b00));
    end
  endtask

  task automatic send_bit(input logic b);
    int g = $urandom_range(0, 2);
    repeat (g) begin
      bit_vld = 1'b0;
      bit_in  = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    bit_vld = 1'b1;
    bit_in  = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) send_bit(1'b1);
  endtask

  task automatic send_frame(input logic [0:FL-1] f, input int probe,
                            input logic [1:0] exp_b, input logic [1:0] exp_a,
                            input string req);
    for (int i = 0; i < FL; i++) begin
      if (i == probe) chk({req, " (before)"}, exp_b);
      send_bit(f[i]);
      if (i == probe) chk(req, exp_a);
    end
  endtask

  task automatic pulse_prog();
    prog_req = 1'b1;
    @(negedge clk);
    prog_req = 1'b0;
  endtask

  task automatic ctl_write(input logic p);
    ctl_we   = 1'b1;
    ctl_prog = p;
    @(negedge clk);
    ctl_we   = 1'b0;
    ctl_prog = 1'b0;
  endtask

  initial begin
    logic [0:FL-1] f;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", 2'b00);

    // R2 R11: clean stream with idle ones, R7 checksum slot position
    idle(3);
    send_frame(build(1'b1), -1, 2'b00, 2'b00, "");
    chk("R2 identifier frame accepted", 2'b00);
    for (int k = 0; k < 3; k++) begin
      idle(k);
      send_frame(build(1'b0), CKL, 2'b00, 2'b00, "R7 checksum ends at length-9");
      chk("R2 data frame accepted", 2'b00);
    end

    // R6: pad bit flipped -> checksum error at last checksum bit
    f = build(1'b0);
    f[2+P+1] = ~f[2+P+1];
    send_frame(f, CKL, 2'b00, 2'b11, "R6 pad bit covered by checksum");
    // R8: later faults ignored while locked
    f = build(1'b0);
    f[FL-2] = 1'b0;
    send_frame(f, -1, 2'b11, 2'b11, "");
    f = build(1'b1);
    f[2] = ~f[2];
    send_frame(f, -1, 2'b11, 2'b11, "");
    chk("R8 first error kept", 2'b11);

    // R10: control write
    ctl_write(1'b0);
    chk("R10 write without program bit ignored", 2'b11);
    ctl_write(1'b1);
    chk("R10 program bit clears", 2'b00);
    // R3 R9: next frame is the identifier frame
    f = build(1'b0);
    f[2] = ~CODE[IDB-1];
    send_frame(f, 1 + IDB, 2'b00, 2'b01, "R3 R9 identifier mismatch after restart");

    // R9 R4
    pulse_prog();
    chk("R9 prog_req clears", 2'b00);
    send_frame(build(1'b1), -1, 2'b00, 2'b00, "");
    f = build(1'b0);
    f[FL-3] = 1'b0;
    send_frame(f, -1, 2'b00, 2'b00, "");
    chk("R4 no flag before next start pair", 2'b00);
    idle(2);
    send_frame(build(1'b0), 1, 2'b00, 2'b10, "R4 bad stop bit flagged at start pair");

    // R5: checksum byte itself wrong on identifier frame
    pulse_prog();
    f = build(1'b1);
    f[HB+3] = ~f[HB+3];
    send_frame(f, CKL, 2'b00, 2'b11, "R5 checksum byte mismatch on identifier frame");

    // R11: a false start pair presented with bit_vld low
    pulse_prog();
    for (int i = 0; i < 10; i++) begin
      bit_vld = 1'b0;
      bit_in  = i[0];
      @(negedge clk);
    end
    send_frame(build(1'b1), -1, 2'b00, 2'b00, "");
    send_frame(build(1'b0), -1, 2'b00, 2'b00, "");
    chk("R11 strobe-low bits ignored", 2'b00);

    // random sequences
    for (int it = 0; it < 40; it++) begin
      int nd;
      pulse_prog();
      idle($urandom_range(0, 3));
      send_frame(build(1'b1), -1, 2'b00, 2'b00, "");
      chk("R2 random identifier frame", 2'b00);
      nd = $urandom_range(1, 3);
      for (int d = 0; d < nd; d++) begin
        int kind = $urandom_range(0, 2);
        f = build(1'b0);
        idle($urandom_range(0, 2));
        if (kind == 0) begin
          send_frame(f, -1, 2'b00, 2'b00, "");
          chk("R2 random data frame", 2'b00);
        end else if (kind == 1) begin
          int p = 2 + $urandom_range(0, P - 1);
          f[p] = ~f[p];
          send_frame(f, CKL, 2'b00, 2'b11, "R5 random payload flip");
          break;
        end else begin
          f[HB+8+$urandom_range(0, 7)] = 1'b0;
          send_frame(f, -1, 2'b00, 2'b00, "");
          idle($urandom_range(0, 2));
          send_frame(build(1'b0), 1, 2'b00, 2'b10, "R4 random stop bit fault");
          break;
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule